// File: doc/BRIEF.md
# Cipher Control Register with Write Lockout

This block is the 32-bit control word of a block-cipher accelerator. It stores the data-swap type, operating mode, chaining mode, DMA request enables, key size, key protection, key handling mode, key-share target, key source and a software reset bit. It also decides which register writes actually land. A write port updates it, and the whole register image is always available on a read bus. The cipher core reports its busy and key-valid status and two completion events back into the block. In return it gets its configuration, an effective DMA enable pair, a level for the software reset, a one-cycle key-erase strobe, and a flag for an illegal chaining code.

The configuration fields are protected. A write to them is dropped while the core is busy. It is also dropped while the block is enabled, unless that same write turns the enable off. The enable bit carries its own checks. It will not set without a valid key, under two forbidden key-mode and chaining combinations, or with a reserved chaining code. Hardware clears it again when key preparation or the initial phase of an authenticated mode finishes.

Top module: `cipher_ctrl_lock`

## Requirements
- R1: After reset every field reads zero: `rd_data_o` is 0, and the enable, soft reset, erase strobe, illegal flag and DMA outputs are low.
- R2: Register layout, as seen on `wr_data_i` and `rd_data_o`:
  - bit 0: enable
  - bits 2:1: swap type
  - bits 4:3: mode (0 encrypt, 1 key preparation, 2 decrypt)
  - bits 6:5: chaining code bits 1:0
  - bit 16: chaining code bit 2
  - bit 11: DMA-in enable
  - bit 12: DMA-out enable
  - bit 18: key size
  - bit 19: key protection
  - bits 25:24: key mode (1 = wrapped)
  - bits 27:26: share ID
  - bits 30:28: key select
  - bit 31: soft reset
  - Chaining codes: 0 ECB, 1 CBC, 2 CTR, 3 GCM/GMAC, 4 CCM.
- R3: A write while `busy_i` is high leaves every configuration field unchanged.
- R4: While enable is 1, a write that keeps bit 0 at 1 changes no configuration field. A write with bit 0 at 0 clears enable and stores its configuration fields in the same cycle.
- R5: Enable stays 0 when a write sets bit 0 while `key_valid_i` is 0. It becomes 1 when the key is valid and the other rules (R6, R9, R11) allow it.
- R6: Enable is refused with key mode 1 and chaining code 3. It is also refused with key mode 1, chaining code 2 and mode 0. Key mode 1 with chaining code 2 and mode 2 is allowed. All checks use the field values in force after the write.
- R7: While enabled, `prep_done_i` in mode 1 clears enable on the next edge. So does `init_done_i` with chaining code 3 or 4. This clear beats a write that sets bit 0 in the same cycle.
- R8: A write with bit 31 set returns all other fields, including enable, to zero. Bit 31 then reads 1 and `soft_rst_o` is high. Until a write with bit 31 clear arrives, configuration writes are ignored. The write that releases the reset does not store its fields.
- R9: Chaining codes 5 to 7 are stored and read back. `illegal_cfg_o` is high while such a code is stored, and enable is refused.
- R10: `dma_in_o` and `dma_out_o` follow their stored bits only in mode 0 or mode 2. In mode 1 or mode 3 they are low.
- R11: An accepted write that changes key select pulses `key_erase_o` for exactly one cycle, after the edge that stores it. A write that asks for enable in the same cycle is refused. Entering soft reset also pulses `key_erase_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register image |
| busy_i | input | 1 | Core busy status |
| key_valid_i | input | 1 | Key registers hold a complete key |
| prep_done_i | input | 1 | Key preparation finished |
| init_done_i | input | 1 | Initial phase of GCM/GMAC/CCM finished |
| enable_o | output | 1 | Block enable |
| swap_o | output | 2 | Data swap type |
| op_mode_o | output | 2 | Operating mode |
| chain_o | output | 3 | Chaining code |
| dma_in_o | output | 1 | Effective DMA-in request enable |
| dma_out_o | output | 1 | Effective DMA-out request enable |
| key_wide_o | output | 1 | Key size select |
| key_prot_o | output | 1 | Key protection |
| key_mode_o | output | 2 | Key handling mode |
| share_id_o | output | 2 | Key-share target |
| key_src_o | output | 3 | Key source select |
| soft_rst_o | output | 1 | Software reset held |
| key_erase_o | output | 1 | One-cycle key-erase strobe |
| illegal_cfg_o | output | 1 | Reserved chaining code stored |

## Verification
The bench targets the lockout edges:
- A busy write. A design that ignored busy would adopt the new mode.
- A write while enabled that keeps bit 0 set, against one that clears it. A design that tested the old enable instead of the written bit would either lose the clearing write or accept the locked one.
- A cycle where a hardware clear meets a write that sets enable. A wrong priority leaves the block enabled after the initial phase.
- Enable requests under each forbidden key-mode and chaining pairing, under the allowed decrypt variant, under a reserved code, and in the same write as a key-select change. A design that checked the old fields would misjudge these.
- The release write after soft reset. A design that stored its fields would show a nonzero image.
- A repeated key select. A design that pulsed erase on every write would strobe twice.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned SWAP_LSB   = 1;
  localparam int unsigned SWAP_W     = 2;
  localparam int unsigned MODE_LSB   = 3;
  localparam int unsigned MODE_W     = 2;
  localparam int unsigned CHN_LO_LSB = 5;
  localparam int unsigned CHN_W      = 3;
  localparam int unsigned CHN_LO_W   = CHN_W - 1;
  localparam int unsigned CHN_HI_BIT = 16;
  localparam int unsigned DMAI_BIT   = 11;
  localparam int unsigned DMAO_BIT   = 12;
  localparam int unsigned KSZ_BIT    = 18;
  localparam int unsigned KPROT_BIT  = 19;
  localparam int unsigned KMOD_LSB   = 24;
  localparam int unsigned KMOD_W     = 2;
  localparam int unsigned SID_LSB    = 26;
  localparam int unsigned SID_W      = 2;
  localparam int unsigned KSEL_LSB   = 28;
  localparam int unsigned KSEL_W     = 3;
  localparam int unsigned SRST_BIT   = 31;

  localparam logic [MODE_W-1:0] OPM_ENC  = 2'd0;
  localparam logic [MODE_W-1:0] OPM_PREP = 2'd1;
  localparam logic [MODE_W-1:0] OPM_DEC  = 2'd2;
  localparam logic [CHN_W-1:0]  CHN_CTR  = 3'd2;
  localparam logic [CHN_W-1:0]  CHN_GCM  = 3'd3;
  localparam logic [CHN_W-1:0]  CHN_CCM  = 3'd4;
  localparam logic [CHN_W-1:0]  CHN_LAST = CHN_CCM;
  localparam logic [KMOD_W-1:0] KMOD_WRAP = 2'd1;

  typedef struct packed {
    logic [KSEL_W-1:0] key_src;
    logic [SID_W-1:0]  share_id;
    logic [KMOD_W-1:0] key_mode;
    logic              key_prot;
    logic              key_wide;
    logic              dma_out;
    logic              dma_in;
    logic [CHN_W-1:0]  chain;
    logic [MODE_W-1:0] op_mode;
    logic [SWAP_W-1:0] swap;
  } cfg_t;

  function automatic cfg_t unpack_cfg(input logic [REG_W-1:0] w);
    cfg_t c;
    c.key_src  = w[KSEL_LSB +: KSEL_W];
    c.share_id = w[SID_LSB +: SID_W];
    c.key_mode = w[KMOD_LSB +: KMOD_W];
    c.key_prot = w[KPROT_BIT];
    c.key_wide = w[KSZ_BIT];
    c.dma_out  = w[DMAO_BIT];
    c.dma_in   = w[DMAI_BIT];
    c.chain    = {w[CHN_HI_BIT], w[CHN_LO_LSB +: CHN_LO_W]};
    c.op_mode  = w[MODE_LSB +: MODE_W];
    c.swap     = w[SWAP_LSB +: SWAP_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_cfg(input cfg_t c, input logic en, input logic srst);
    logic [REG_W-1:0] w;
    w = '0;
    w[EN_BIT]                  = en;
    w[SWAP_LSB +: SWAP_W]      = c.swap;
    w[MODE_LSB +: MODE_W]      = c.op_mode;
    w[CHN_LO_LSB +: CHN_LO_W]  = c.chain[CHN_LO_W-1:0];
    w[CHN_HI_BIT]              = c.chain[CHN_W-1];
    w[DMAI_BIT]                = c.dma_in;
    w[DMAO_BIT]                = c.dma_out;
    w[KSZ_BIT]                 = c.key_wide;
    w[KPROT_BIT]               = c.key_prot;
    w[KMOD_LSB +: KMOD_W]      = c.key_mode;
    w[SID_LSB +: SID_W]        = c.share_id;
    w[KSEL_LSB +: KSEL_W]      = c.key_src;
    w[SRST_BIT]                = srst;
    return w;
  endfunction

  // enable-compatible configuration
  function automatic logic cfg_legal(input cfg_t c);
    logic wrap_bad;
    wrap_bad = (c.key_mode == KMOD_WRAP) &&
               ((c.chain == CHN_GCM) || ((c.chain == CHN_CTR) && (c.op_mode == OPM_ENC)));
    return !wrap_bad && (c.chain <= CHN_LAST);
  endfunction
endpackage

// File: rtl/ccr_field_store.sv
module ccr_field_store
  import ccr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             busy_i,
  input  logic             en_q_i,
  output cfg_t             cfg_o,
  output logic             cand_legal_o,
  output logic             src_change_o,
  output logic             srst_o,
  output logic             erase_o
);
  cfg_t cfg_q, cfg_d;
  logic srst_q, erase_q;
  logic srst_req, en_kept, cfg_take;
  logic unused_bits;

  assign unused_bits = ^{wr_data_i[10:7], wr_data_i[15:13], wr_data_i[17], wr_data_i[23:20]};

  assign srst_req = wr_en_i && wr_data_i[SRST_BIT];
  assign en_kept  = en_q_i && wr_data_i[EN_BIT];
  assign cfg_take = wr_en_i && !wr_data_i[SRST_BIT] && !srst_q && !busy_i && !en_kept;

  always_comb begin
    cfg_d = cfg_q;
    if (srst_req)      cfg_d = '0;
    else if (cfg_take) cfg_d = unpack_cfg(wr_data_i);
  end

  assign src_change_o = (cfg_d.key_src != cfg_q.key_src);
  assign cand_legal_o = cfg_legal(cfg_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      srst_q  <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      if (wr_en_i) srst_q <= wr_data_i[SRST_BIT];
      erase_q <= src_change_o || (srst_req && !srst_q);
    end
  end

  assign cfg_o   = cfg_q;
  assign srst_o  = srst_q;
  assign erase_o = erase_q;
endmodule

// File: rtl/ccr_enable_ctl.sv
module ccr_enable_ctl
  import ccr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_en_bit_i,
  input  logic              wr_srst_bit_i,
  input  logic              srst_q_i,
  input  logic              cand_legal_i,
  input  logic              src_change_i,
  input  logic              key_valid_i,
  input  logic              prep_done_i,
  input  logic              init_done_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [CHN_W-1:0]  cur_chain_i,
  output logic              en_o
);
  logic en_q, en_d, hw_clr, set_ok;

  assign hw_clr = en_q &&
                  ((prep_done_i && (cur_mode_i == OPM_PREP)) ||
                   (init_done_i && ((cur_chain_i == CHN_GCM) || (cur_chain_i == CHN_CCM))));

  assign set_ok = key_valid_i && cand_legal_i && !src_change_i && !srst_q_i;

  always_comb begin
    en_d = en_q;
    if (srst_q_i || (wr_en_i && wr_srst_bit_i)) en_d = 1'b0;
    else if (hw_clr)                            en_d = 1'b0;
    else if (wr_en_i) begin
      if (!wr_en_bit_i) en_d = 1'b0;
      else if (!en_q)   en_d = set_ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/ccr_out_map.sv
module ccr_out_map
  import ccr_pkg::*;
(
  input  cfg_t             cfg_i,
  input  logic             en_i,
  input  logic             srst_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             dma_in_o,
  output logic             dma_out_o,
  output logic             illegal_o
);
  logic dma_mode;

  assign rd_data_o = pack_cfg(cfg_i, en_i, srst_i);
  assign dma_mode  = (cfg_i.op_mode == OPM_ENC) || (cfg_i.op_mode == OPM_DEC);
  assign dma_in_o  = cfg_i.dma_in && dma_mode;
  assign dma_out_o = cfg_i.dma_out && dma_mode;
  assign illegal_o = cfg_i.chain > CHN_LAST;
endmodule

// File: rtl/cipher_ctrl_lock.sv
module cipher_ctrl_lock
  import ccr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              busy_i,
  input  logic              key_valid_i,
  input  logic              prep_done_i,
  input  logic              init_done_i,
  output logic              enable_o,
  output logic [SWAP_W-1:0] swap_o,
  output logic [MODE_W-1:0] op_mode_o,
  output logic [CHN_W-1:0]  chain_o,
  output logic              dma_in_o,
  output logic              dma_out_o,
  output logic              key_wide_o,
  output logic              key_prot_o,
  output logic [KMOD_W-1:0] key_mode_o,
  output logic [SID_W-1:0]  share_id_o,
  output logic [KSEL_W-1:0] key_src_o,
  output logic              soft_rst_o,
  output logic              key_erase_o,
  output logic              illegal_cfg_o
);
  cfg_t cfg;
  logic en, cand_legal, src_change, srst;

  ccr_field_store u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .busy_i       (busy_i),
    .en_q_i       (en),
    .cfg_o        (cfg),
    .cand_legal_o (cand_legal),
    .src_change_o (src_change),
    .srst_o       (srst),
    .erase_o      (key_erase_o)
  );

  ccr_enable_ctl u_en (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_en_bit_i   (wr_data_i[EN_BIT]),
    .wr_srst_bit_i (wr_data_i[SRST_BIT]),
    .srst_q_i      (srst),
    .cand_legal_i  (cand_legal),
    .src_change_i  (src_change),
    .key_valid_i   (key_valid_i),
    .prep_done_i   (prep_done_i),
    .init_done_i   (init_done_i),
    .cur_mode_i    (cfg.op_mode),
    .cur_chain_i   (cfg.chain),
    .en_o          (en)
  );

  ccr_out_map u_map (
    .cfg_i     (cfg),
    .en_i      (en),
    .srst_i    (srst),
    .rd_data_o (rd_data_o),
    .dma_in_o  (dma_in_o),
    .dma_out_o (dma_out_o),
    .illegal_o (illegal_cfg_o)
  );

  assign enable_o   = en;
  assign swap_o     = cfg.swap;
  assign op_mode_o  = cfg.op_mode;
  assign chain_o    = cfg.chain;
  assign key_wide_o = cfg.key_wide;
  assign key_prot_o = cfg.key_prot;
  assign key_mode_o = cfg.key_mode;
  assign share_id_o = cfg.share_id;
  assign key_src_o  = cfg.key_src;
  assign soft_rst_o = srst;
endmodule

// File: rtl/ccr_lock_checker.sv
module ccr_lock_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [31:0] wr_data_i,
  input logic       busy_i,
  input logic       key_valid_i,
  input logic       prep_done_i,
  input logic       enable_o,
  input logic [1:0] op_mode_o,
  input logic [2:0] chain_o,
  input logic       dma_in_o,
  input logic       dma_out_o,
  input logic [1:0] key_mode_o,
  input logic [2:0] key_src_o,
  input logic       soft_rst_o,
  input logic       key_erase_o,
  input logic       illegal_cfg_o
);
  a_r3_busy_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !(wr_en_i && wr_data_i[31])) |=>
      ($stable(op_mode_o) && $stable(chain_o) && $stable(key_src_o)));

  a_r5_key_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_o) |-> $past(key_valid_i));

  a_r6_no_forbidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_o |-> !((key_mode_o == 2'd1) &&
                   ((chain_o == 3'd3) || ((chain_o == 3'd2) && (op_mode_o == 2'd0)))));

  a_r7_prep_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o && prep_done_i && (op_mode_o == 2'd1)) |=> !enable_o);

  a_r8_reset_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (!enable_o && (key_src_o == 3'd0) && (op_mode_o == 2'd0)));

  a_r9_illegal_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_cfg_o |-> !enable_o);

  a_r10_dma_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_in_o || dma_out_o) |-> ((op_mode_o == 2'd0) || (op_mode_o == 2'd2)));

  a_r11_erase_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_src_o != $past(key_src_o)) |-> key_erase_o);
endmodule

bind cipher_ctrl_lock ccr_lock_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .busy_i        (busy_i),
  .key_valid_i   (key_valid_i),
  .prep_done_i   (prep_done_i),
  .enable_o      (enable_o),
  .op_mode_o     (op_mode_o),
  .chain_o       (chain_o),
  .dma_in_o      (dma_in_o),
  .dma_out_o     (dma_out_o),
  .key_mode_o    (key_mode_o),
  .key_src_o     (key_src_o),
  .soft_rst_o    (soft_rst_o),
  .key_erase_o   (key_erase_o),
  .illegal_cfg_o (illegal_cfg_o)
);

// File: tb/tb_cipher_ctrl_lock.sv
`timescale 1ns/1ps
module tb_cipher_ctrl_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        busy = 1'b0, kv = 1'b0, pd = 1'b0, idn = 1'b0;
  logic [31:0] rd_data;
  logic        enable, dma_in, dma_out, key_wide, key_prot, soft_rst, key_erase, illegal;
  logic [1:0]  swap, op_mode, key_mode, share_id;
  logic [2:0]  chain, key_src;

  int n_vec = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cipher_ctrl_lock dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .busy_i(busy), .key_valid_i(kv), .prep_done_i(pd), .init_done_i(idn),
    .enable_o(enable), .swap_o(swap), .op_mode_o(op_mode), .chain_o(chain),
    .dma_in_o(dma_in), .dma_out_o(dma_out), .key_wide_o(key_wide), .key_prot_o(key_prot),
    .key_mode_o(key_mode), .share_id_o(share_id), .key_src_o(key_src),
    .soft_rst_o(soft_rst), .key_erase_o(key_erase), .illegal_cfg_o(illegal)
  );

  typedef struct {
    logic [31:0] rd;
    logic        er;
    logic        il;
    logic [1:0]  dma;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // layout per R2
  function automatic logic [31:0] mk(input logic en, input logic [1:0] sw, input logic [1:0] md,
                                     input logic [2:0] ch, input logic di, input logic dmo,
                                     input logic ksz, input logic kp, input logic [1:0] km,
                                     input logic [1:0] sid, input logic [2:0] ks, input logic sr);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[2:1] = sw; w[4:3] = md; w[6:5] = ch[1:0]; w[16] = ch[2];
    w[11] = di; w[12] = dmo; w[18] = ksz; w[19] = kp; w[25:24] = km;
    w[27:26] = sid; w[30:28] = ks; w[31] = sr;
    return w;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] xp);
    if (act !== xp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, xp);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] wd, input logic bz, input logic k,
                      input logic p, input logic i, input logic [31:0] xrd, input logic xer,
                      input logic xil, input logic [1:0] xdma, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = wd; busy = bz; kv = k; pd = p; idn = i;
    e.rd = xrd; e.er = xer; e.il = xil; e.dma = xdma; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        cmp(e.tag, "rd_data", rd_data, e.rd);
        cmp(e.tag, "enable", {31'd0, enable}, {31'd0, e.rd[0]});
        cmp(e.tag, "soft_rst", {31'd0, soft_rst}, {31'd0, e.rd[31]});
        cmp(e.tag, "key_erase", {31'd0, key_erase}, {31'd0, e.er});
        cmp(e.tag, "illegal", {31'd0, illegal}, {31'd0, e.il});
        cmp(e.tag, "dma", {30'd0, dma_out, dma_in}, {30'd0, e.dma});
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w1, w2, w3, w4, w5, w6, w7, w8, w9, w10, w11, w12, w13;
    w1  = mk(0, 2'd2, 2'd0, 3'd1, 1, 1, 1, 0, 2'd0, 2'd0, 3'd0, 0);
    w2  = mk(0, 2'd1, 2'd2, 3'd2, 0, 0, 0, 1, 2'd0, 2'd1, 3'd0, 0);
    w3  = mk(0, 2'd3, 2'd2, 3'd0, 1, 0, 0, 0, 2'd0, 2'd0, 3'd0, 0);
    w4  = mk(0, 2'd0, 2'd1, 3'd0, 1, 1, 0, 0, 2'd0, 2'd0, 3'd0, 0);
    w5  = mk(0, 2'd0, 2'd0, 3'd3, 0, 0, 0, 0, 2'd1, 2'd0, 3'd0, 0);
    w6  = mk(0, 2'd0, 2'd0, 3'd2, 0, 0, 0, 0, 2'd1, 2'd0, 3'd0, 0);
    w7  = mk(0, 2'd0, 2'd2, 3'd2, 0, 0, 0, 0, 2'd1, 2'd0, 3'd0, 0);
    w8  = mk(0, 2'd0, 2'd0, 3'd3, 0, 0, 0, 0, 2'd0, 2'd0, 3'd0, 0);
    w9  = mk(0, 2'd0, 2'd0, 3'd5, 0, 0, 0, 0, 2'd0, 2'd0, 3'd0, 0);
    w10 = mk(0, 2'd0, 2'd0, 3'd0, 0, 0, 0, 0, 2'd0, 2'd0, 3'd1, 0);
    w11 = mk(0, 2'd0, 2'd0, 3'd0, 0, 0, 0, 0, 2'd0, 2'd0, 3'd2, 0);
    w12 = mk(0, 2'd0, 2'd3, 3'd0, 1, 1, 0, 0, 2'd0, 2'd0, 3'd0, 0);
    w13 = mk(0, 2'd1, 2'd2, 3'd7, 1, 1, 0, 1, 2'd0, 2'd3, 3'd0, 0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step(0, 32'd0,     0, 0, 0, 0, 32'd0,     0, 0, 2'b00, "R1 reset image");
    step(1, w1,        0, 0, 0, 0, w1,        0, 0, 2'b11, "R2 field placement");
    step(1, w2,        1, 0, 0, 0, w1,        0, 0, 2'b11, "R3 busy write dropped");
    step(1, w1 | 1,    0, 0, 0, 0, w1,        0, 0, 2'b11, "R5 enable refused without key");
    step(1, w1 | 1,    0, 1, 0, 0, w1 | 1,    0, 0, 2'b11, "R5 enable with valid key");
    step(1, w3 | 1,    0, 1, 0, 0, w1 | 1,    0, 0, 2'b11, "R4 locked while enabled");
    step(1, w3,        0, 1, 0, 0, w3,        0, 0, 2'b01, "R4 clearing write stores fields");
    step(1, w4,        0, 1, 0, 0, w4,        0, 0, 2'b00, "R10 dma masked in key prep");
    step(1, w4 | 1,    0, 1, 0, 0, w4 | 1,    0, 0, 2'b00, "R7 enable for key prep");
    step(0, 32'd0,     0, 1, 1, 0, w4,        0, 0, 2'b00, "R7 prep done clears enable");
    step(1, w5 | 1,    0, 1, 0, 0, w5,        0, 0, 2'b00, "R6 wrapped GCM refused");
    step(1, w6 | 1,    0, 1, 0, 0, w6,        0, 0, 2'b00, "R6 wrapped CTR encrypt refused");
    step(1, w7 | 1,    0, 1, 0, 0, w7 | 1,    0, 0, 2'b00, "R6 wrapped CTR decrypt allowed");
    step(1, w7,        0, 1, 0, 0, w7,        0, 0, 2'b00, "R4 clear enable");
    step(1, w8 | 1,    0, 1, 0, 0, w8 | 1,    0, 0, 2'b00, "R7 GCM enable");
    step(1, w8 | 1,    0, 1, 0, 1, w8,        0, 0, 2'b00, "R7 init done beats set");
    step(1, w9 | 1,    0, 1, 0, 0, w9,        0, 1, 2'b00, "R9 reserved chain stored, enable refused");
    step(1, w10,       0, 1, 0, 0, w10,       1, 0, 2'b00, "R11 select change erases");
    step(1, w10,       0, 1, 0, 0, w10,       0, 0, 2'b00, "R11 same select no erase");
    step(1, w11 | 1,   0, 1, 0, 0, w11,       1, 0, 2'b00, "R11 enable refused with select change");
    step(1, w1 | 32'h8000_0001, 0, 1, 0, 0, 32'h8000_0000, 1, 0, 2'b00, "R8 soft reset clears fields");
    step(1, w1,        0, 1, 0, 0, 32'd0,     0, 0, 2'b00, "R8 release write not stored");
    step(1, w1,        0, 1, 0, 0, w1,        0, 0, 2'b11, "R8 write after release");
    step(1, w12,       0, 1, 0, 0, w12,       0, 0, 2'b00, "R10 dma masked in mode 3");
    step(1, w13,       0, 1, 0, 0, w13,       0, 1, 2'b11, "R9 chain 7 flagged, R10 dma live in decrypt");
    step(0, 32'd0,     0, 0, 0, 0, w13,       0, 1, 2'b11, "R3 idle hold");

    wait (sb_q.size() == 0);
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule